// File: doc/BRIEF.md
# Pillarboxed Interlaced 4:2:2 Byte Stream Generator

This block turns a 320-by-240 image in an external frame store into a continuous 8-bit stream of 4:2:2 YCbCr for a 525-line interlaced video encoder. It emits one byte per clock at the encoder's 27 MHz byte rate. It counts bytes within a line and lines within a frame, and it inserts the four-byte timing reference codes that mark the start and end of each line's active region. Everywhere that no picture is carried, it fills the line with blanking data.

Each field carries 240 active lines, so the source image is shown once in the odd field and once in the even field. Within a line, every source pixel is repeated across two luma positions and the two positions share one chroma pair. This widens a 320-pixel row to 640 samples. The row is then centred in the 720-sample active line, with 40 black samples on each side.

Pixels are fetched through a simple read port. A single-cycle request carries a row and column address, and the store must present that pixel on the cycle that follows the request. Each output byte comes with field, vertical-blank and horizontal-blank flags that are aligned to it.

Top module: `pbox_stream_gen`

## Requirements
- R1: A line is 1716 bytes long. Bytes 0..3 are the end-of-active code FF 00 00 XY with H=1. Bytes 272..275 are the start-of-active code FF 00 00 XY with H=0. Bytes 276..1715 are the 1440 active bytes.
- R2: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0.
- R3: A frame has VB_TOP + VB_MID + 2*IMG_ROWS lines, which is 525 with the defaults. Lines are numbered from 1 and wrap to 1. V=1 on lines 1..VB_TOP (1..22) and on VB_MID lines (263..285) after the odd field's active lines. F=1 from line 263 through the last line, and F=0 elsewhere.
- R4: Bytes 4..271 alternate 0x80, 0x10, 0x80, ... starting with 0x80 at byte 4.
- R5: On picture lines, the first 80 and the last 80 active bytes are black margin. They alternate 0x80 (chroma) and 0x10 (luma), starting with 0x80 at active byte 0.
- R6: Active bytes 80..1359 carry the image as Cb, Y, Cr, Y per source pixel. Each source pixel fills 4 bytes. pixData is {Y[23:16], Cb[15:8], Cr[7:0]}.
- R7: pixReq is high for exactly one cycle, one byte before each pixel's Cb byte is computed. pixData must hold that pixel in the following cycle. pixCol counts 0..319 across the line. pixRow is the line number minus 23 in the odd field and minus 286 in the even field.
- R8: Image bytes are clipped so that 0x00 becomes 0x01 and 0xFF becomes 0xFE. A byte of 0xFF on the output is therefore always followed by 0x00.
- R9: On vertical-blank lines, pixReq never rises, and all 1440 active bytes alternate 0x80, 0x10.
- R10: byteOut, fieldOut, vBlankOut and hBlankOut are registered together. Each output byte is valid one cycle after its position is counted. hBlankOut is 1 on bytes 0..275 and 0 on active bytes.
- R11: While rstN is low, byteOut is 0x10, hBlankOut and vBlankOut are 1, fieldOut is 0 and pixReq is 0. The first byte after reset is the first byte of line 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | 24 | Pixel from the frame store, {Y, Cb, Cr} |
| pixReq | output | 1 | Single-cycle pixel read request |
| pixRow | output | $clog2(IMG_ROWS) | Source row of the request |
| pixCol | output | $clog2(IMG_COLS) | Source column of the request |
| byteOut | output | 8 | Output stream byte |
| fieldOut | output | 1 | F flag aligned to byteOut |
| vBlankOut | output | 1 | V flag aligned to byteOut |
| hBlankOut | output | 1 | 1 on code and horizontal blanking bytes |

## Verification
Every byte of the stream is checked across one full frame and into the next. This covers both blanking splits, the wrap from the last line to line 1, and the F and V changes in the XY codes. Checking every byte catches an off-by-one blanking span or a wrong protection bit. The stored test pattern includes source values of 0x00 and 0xFF, so a design that does not clip would put a false timing code into the picture. The first and last source pixels of each row are checked, along with the request timing. A margin one pixel short, or a request one cycle late, shifts the whole image and shows up as byte mismatches.

// File: rtl/pbox_pkg.sv
package pbox_pkg;

  // Strobes from the timing control to the byte datapath, valid for the
  // byte position currently being counted.
  typedef struct packed {
    logic       trc;      // byte belongs to a timing reference code
    logic [1:0] trcIdx;   // index inside the code
    logic       image;    // byte carries image data
    logic [1:0] phase;    // Cb, Y, Cr, Y slot inside a source pixel
    logic       capture;  // store the fetched pixel this cycle
    logic       fBit;
    logic       vBit;
    logic       hBit;     // 1 for the end-of-active code
    logic       hBlank;   // byte lies before the active region
    logic       oddByte;  // luma slot of a blanking pair
  } ctlStrobe_t;

  function automatic logic [7:0] trcWord(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] clipByte(input logic [7:0] x);
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

endpackage

// File: rtl/pbox_timing.sv
module pbox_timing
  import pbox_pkg::*;
#(
  parameter int IMG_COLS     = 320,
  parameter int IMG_ROWS     = 240,
  parameter int MARGIN       = 40,
  parameter int HBLANK_BYTES = 268,
  parameter int VB_TOP       = 22,
  parameter int VB_MID       = 23,
  localparam int ROW_W = (IMG_ROWS > 1) ? $clog2(IMG_ROWS) : 1,
  localparam int COL_W = (IMG_COLS > 1) ? $clog2(IMG_COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  output ctlStrobe_t       ctl,
  output logic             pixReq,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol
);

  localparam int LINE_INT  = 8 + HBLANK_BYTES + 4 * MARGIN + 4 * IMG_COLS;
  localparam int TOTAL_INT = VB_TOP + VB_MID + 2 * IMG_ROWS;
  localparam int H_W = $clog2(LINE_INT);
  localparam int L_W = $clog2(TOTAL_INT + 1);

  localparam logic [H_W-1:0] LINE_LAST = H_W'(LINE_INT - 1);
  localparam logic [H_W-1:0] SAV_POS   = H_W'(4 + HBLANK_BYTES);
  localparam logic [H_W-1:0] SAV_END   = H_W'(8 + HBLANK_BYTES);
  localparam logic [H_W-1:0] ACT_START = H_W'(8 + HBLANK_BYTES);
  localparam logic [H_W-1:0] IMG_START = H_W'(8 + HBLANK_BYTES + 2 * MARGIN);
  localparam logic [H_W-1:0] IMG_END   = H_W'(8 + HBLANK_BYTES + 2 * MARGIN + 4 * IMG_COLS);
  localparam logic [H_W-1:0] REQ_START = H_W'(7 + HBLANK_BYTES + 2 * MARGIN);
  localparam logic [H_W-1:0] REQ_END   = H_W'(7 + HBLANK_BYTES + 2 * MARGIN + 4 * IMG_COLS);
  localparam logic [H_W-1:0] FILL_BASE = H_W'(4);

  localparam logic [L_W-1:0] TOTAL_LINES = L_W'(TOTAL_INT);
  localparam logic [L_W-1:0] VB_TOP_L    = L_W'(VB_TOP);
  localparam logic [L_W-1:0] ODD_FIRST   = L_W'(VB_TOP + 1);
  localparam logic [L_W-1:0] MID_FIRST   = L_W'(VB_TOP + IMG_ROWS + 1);
  localparam logic [L_W-1:0] EVEN_FIRST  = L_W'(VB_TOP + IMG_ROWS + VB_MID + 1);
  localparam logic [ROW_W:0] ROW_LIMIT   = (ROW_W + 1)'(IMG_ROWS);

  logic [H_W-1:0] hCnt;
  logic [L_W-1:0] lineNum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt    <= '0;
      lineNum <= L_W'(1);
    end else if (hCnt == LINE_LAST) begin
      hCnt    <= '0;
      lineNum <= (lineNum == TOTAL_LINES) ? L_W'(1) : lineNum + L_W'(1);
    end else begin
      hCnt <= hCnt + H_W'(1);
    end
  end

  logic vLine, fLine, isEav, isSav, inImage, inReq;
  logic [H_W-1:0] savRel, imgRel, reqRel, fillRel;
  logic [L_W-1:0] rowBase;

  always_comb begin
    vLine   = (lineNum <= VB_TOP_L) || ((lineNum >= MID_FIRST) && (lineNum < EVEN_FIRST));
    fLine   = (lineNum >= MID_FIRST);
    isEav   = (hCnt < H_W'(4));
    isSav   = (hCnt >= SAV_POS) && (hCnt < SAV_END);
    savRel  = hCnt - SAV_POS;
    imgRel  = hCnt - IMG_START;
    reqRel  = hCnt - REQ_START;
    fillRel = hCnt - FILL_BASE;
    inImage = !vLine && (hCnt >= IMG_START) && (hCnt < IMG_END);
    inReq   = !vLine && (hCnt >= REQ_START) && (hCnt < REQ_END);
    rowBase = fLine ? EVEN_FIRST : ODD_FIRST;

    ctl.trc     = isEav || isSav;
    ctl.trcIdx  = isEav ? hCnt[1:0] : savRel[1:0];
    ctl.image   = inImage;
    ctl.phase   = imgRel[1:0];
    ctl.capture = inImage && (imgRel[1:0] == 2'd0);
    ctl.fBit    = fLine;
    ctl.vBit    = vLine;
    ctl.hBit    = isEav;
    ctl.hBlank  = (hCnt < ACT_START);
    ctl.oddByte = fillRel[0];

    pixReq = inReq && (reqRel[1:0] == 2'd0);
    pixCol = COL_W'(reqRel >> 2);
    pixRow = ROW_W'(lineNum - rowBase);
  end

  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= LINE_LAST);  // R1

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt == LINE_LAST && lineNum == TOTAL_LINES) |=> (lineNum == L_W'(1)));  // R3

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> !pixReq);  // R7

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |-> ({1'b0, pixRow} < ROW_LIMIT));  // R7

endmodule

// File: rtl/pbox_datapath.sv
module pbox_datapath
  import pbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  ctl,
  input  logic [23:0] pixData,
  output logic [7:0]  byteOut,
  output logic        fieldOut,
  output logic        vBlankOut,
  output logic        hBlankOut
);

  // Held luma and red chroma of the pixel being spread over four bytes.
  logic [7:0] lumaHold;
  logic [7:0] crHold;
  logic [7:0] nextByte;

  always_comb begin
    if (ctl.trc) begin
      unique case (ctl.trcIdx)
        2'd0:    nextByte = 8'hFF;
        2'd3:    nextByte = trcWord(ctl.fBit, ctl.vBit, ctl.hBit);
        default: nextByte = 8'h00;
      endcase
    end else if (ctl.image) begin
      unique case (ctl.phase)
        2'd0:    nextByte = clipByte(pixData[15:8]);
        2'd2:    nextByte = clipByte(crHold);
        default: nextByte = clipByte(lumaHold);
      endcase
    end else begin
      nextByte = ctl.oddByte ? 8'h10 : 8'h80;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteOut   <= 8'h10;
      fieldOut  <= 1'b0;
      vBlankOut <= 1'b1;
      hBlankOut <= 1'b1;
      lumaHold  <= 8'h10;
      crHold    <= 8'h80;
    end else begin
      byteOut   <= nextByte;
      fieldOut  <= ctl.fBit;
      vBlankOut <= ctl.vBit;
      hBlankOut <= ctl.hBlank;
      if (ctl.capture) begin
        lumaHold <= pixData[23:16];
        crHold   <= pixData[7:0];
      end
    end
  end

  AST_FF_THEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (byteOut == 8'hFF) |=> (byteOut == 8'h00));  // R8

  AST_ACTIVE_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    !hBlankOut |-> (byteOut != 8'h00 && byteOut != 8'hFF));  // R8

  AST_VBLANK_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (vBlankOut && !hBlankOut) |-> (byteOut == 8'h80 || byteOut == 8'h10));  // R9

endmodule

// File: rtl/pbox_stream_gen.sv
module pbox_stream_gen
  import pbox_pkg::*;
#(
  parameter int IMG_COLS     = 320,
  parameter int IMG_ROWS     = 240,
  parameter int MARGIN       = 40,
  parameter int HBLANK_BYTES = 268,
  parameter int VB_TOP       = 22,
  parameter int VB_MID       = 23,
  localparam int ROW_W = (IMG_ROWS > 1) ? $clog2(IMG_ROWS) : 1,
  localparam int COL_W = (IMG_COLS > 1) ? $clog2(IMG_COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [23:0]      pixData,
  output logic             pixReq,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  output logic [7:0]       byteOut,
  output logic             fieldOut,
  output logic             vBlankOut,
  output logic             hBlankOut
);

  ctlStrobe_t ctl;

  pbox_timing #(
    .IMG_COLS    (IMG_COLS),
    .IMG_ROWS    (IMG_ROWS),
    .MARGIN      (MARGIN),
    .HBLANK_BYTES(HBLANK_BYTES),
    .VB_TOP      (VB_TOP),
    .VB_MID      (VB_MID)
  ) uTiming (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .pixReq(pixReq),
    .pixRow(pixRow),
    .pixCol(pixCol)
  );

  pbox_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pixData  (pixData),
    .byteOut  (byteOut),
    .fieldOut (fieldOut),
    .vBlankOut(vBlankOut),
    .hBlankOut(hBlankOut)
  );

endmodule

// File: tb/tb_pbox_stream_gen.sv
module tb_pbox_stream_gen;

  localparam int IMG_COLS = 320;
  localparam int IMG_ROWS = 8;     // short fields keep the run bounded
  localparam int MARGIN   = 40;
  localparam int HBL      = 268;
  localparam int VB_TOP   = 22;
  localparam int VB_MID   = 23;
  localparam int ROW_W    = $clog2(IMG_ROWS);
  localparam int COL_W    = $clog2(IMG_COLS);

  localparam int LINE_BYTES = 1716;
  localparam int SAV_POS    = 272;
  localparam int ACT_START  = 276;
  localparam int TOTAL      = VB_TOP + VB_MID + 2 * IMG_ROWS;
  localparam int MID_FIRST  = VB_TOP + IMG_ROWS + 1;
  localparam int EVEN_FIRST = MID_FIRST + VB_MID;
  localparam int RUN_LINES  = TOTAL + 2;
  localparam int RUN_CYC    = RUN_LINES * LINE_BYTES;

  typedef struct {
    logic [7:0] b;
    logic       f;
    logic       v;
    logic       h;
    int         tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [23:0]      pixData = '0;
  logic             pixReq;
  logic [ROW_W-1:0] pixRow;
  logic [COL_W-1:0] pixCol;
  logic [7:0]       byteOut;
  logic             fieldOut, vBlankOut, hBlankOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  item_t q[$];

  always #4 clk = ~clk;

  pbox_stream_gen #(
    .IMG_COLS(IMG_COLS), .IMG_ROWS(IMG_ROWS), .MARGIN(MARGIN),
    .HBLANK_BYTES(HBL), .VB_TOP(VB_TOP), .VB_MID(VB_MID)
  ) dut (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixReq(pixReq),
    .pixRow(pixRow), .pixCol(pixCol), .byteOut(byteOut),
    .fieldOut(fieldOut), .vBlankOut(vBlankOut), .hBlankOut(hBlankOut)
  );

  function automatic logic [23:0] pixFn(int row, int col);
    logic [7:0] y, cb, cr;
    y  = 8'((col * 3 + row) & 255);
    cb = 8'(255 - (col & 255));
    cr = 8'((col + row * 5) & 255);
    return {y, cb, cr};
  endfunction

  // Frame store model: one cycle of read latency.
  always @(posedge clk) if (pixReq) pixData <= pixFn(int'(pixRow), int'(pixCol));

  function automatic logic vOf(int ln);
    return (ln <= VB_TOP) || (ln >= MID_FIRST && ln < EVEN_FIRST);
  endfunction

  function automatic logic fOf(int ln);
    return ln >= MID_FIRST;
  endfunction

  function automatic logic [7:0] clipB(logic [7:0] x);
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

  function automatic logic [7:0] codeByte(int idx, logic f, logic v, logic h);
    if (idx == 0) return 8'hFF;
    if (idx < 3) return 8'h00;
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic item_t expItem(int ln, int h);
    item_t it;
    int a, b, row;
    logic [23:0] px;
    logic [7:0] raw;
    it.f = fOf(ln);
    it.v = vOf(ln);
    it.h = (h < ACT_START);
    if (h < 4) begin
      it.tag = (h == 3) ? 2 : 1;            // R1 / R2, H=1
      it.b = codeByte(h, it.f, it.v, 1'b1);
    end else if (h >= SAV_POS && h < SAV_POS + 4) begin
      it.tag = (h == SAV_POS + 3) ? 2 : 1;  // R1 / R2, H=0
      it.b = codeByte(h - SAV_POS, it.f, it.v, 1'b0);
    end else if (h < SAV_POS) begin
      it.tag = 4;                           // R4
      it.b = ((h - 4) % 2 == 0) ? 8'h80 : 8'h10;
    end else begin
      a = h - ACT_START;
      if (it.v) begin
        it.tag = 9;                         // R9
        it.b = (a % 2 == 0) ? 8'h80 : 8'h10;
      end else if (a < 2 * MARGIN || a >= 2 * MARGIN + 4 * IMG_COLS) begin
        it.tag = 5;                         // R5
        it.b = (a % 2 == 0) ? 8'h80 : 8'h10;
      end else begin
        b = a - 2 * MARGIN;
        row = it.f ? ln - EVEN_FIRST : ln - VB_TOP - 1;
        px = pixFn(row, b / 4);
        case (b % 4)
          0: raw = px[15:8];
          2: raw = px[7:0];
          default: raw = px[23:16];
        endcase
        it.tag = (raw == 8'h00 || raw == 8'hFF) ? 8 : 6;  // R8 / R6
        it.b = clipB(raw);
      end
    end
    return it;
  endfunction

  function automatic string tagStr(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: pushes the expected stream, line by line.
  task automatic pushLines(int nLines);
    int ln = 1;
    for (int i = 0; i < nLines; i++) begin
      for (int h = 0; h < LINE_BYTES; h++) q.push_back(expItem(ln, h));
      ln = (ln == TOTAL) ? 1 : ln + 1;
    end
  endtask

  initial begin
    pushLines(RUN_LINES);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(byteOut == 8'h10, "R11", "reset byteOut", byteOut, 8'h10);
    check(hBlankOut && vBlankOut && !fieldOut, "R11", "reset flags",
          {fieldOut, vBlankOut, hBlankOut}, 3'b011);
    check(!pixReq, "R11", "reset pixReq", pixReq, 0);
    rstN = 1'b1;
    begin
      int ln = 1;
      int h = 0;
      for (int k = 0; k < RUN_CYC; k++) begin
        bit expReq;
        int rel;
        rel = h - (ACT_START + 2 * MARGIN - 1);
        expReq = !vOf(ln) && rel >= 0 && rel < 4 * IMG_COLS && (rel % 4 == 0);
        check(pixReq == expReq, "R7", "pixReq", pixReq, expReq);  // R9 on blank lines
        if (expReq) begin
          int er;
          er = fOf(ln) ? ln - EVEN_FIRST : ln - VB_TOP - 1;
          check(int'(pixCol) == rel / 4, "R7", "pixCol", pixCol, rel / 4);
          check(int'(pixRow) == er, "R7", "pixRow", pixRow, er);
        end
        if (k >= 1) begin
          item_t it;
          it = q.pop_front();
          check(byteOut == it.b, tagStr(it.tag), "byteOut", byteOut, it.b);
          check(fieldOut == it.f && vBlankOut == it.v, "R3", "field/vblank",
                {fieldOut, vBlankOut}, {it.f, it.v});
          check(hBlankOut == it.h, "R10", "hBlank", hBlankOut, it.h);
        end
        h++;
        if (h == LINE_BYTES) begin
          h = 0;
          ln = (ln == TOTAL) ? 1 : ln + 1;
        end
        @(negedge clk);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (RUN_CYC + 20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule